// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

A small synchronous static memory with a 32-bit word split into four 8-bit lanes. Address, control and write data are captured at the rising clock edge. A read then passes through the array into an output register, so read data is presented one edge after the address edge. Writes are timed by the clock alone. A write either covers the whole word or only the lanes chosen by a per-lane mask.

An access is opened by one of two start strobes, and only while all three chip-select inputs are in their active state. After that, a two-bit offset counter walks through a four-word block in either a wrapping linear order or an XOR (interleaved) order. The counter moves only while the advance input is low. A start strobe that finds the chip unselected closes the access, and the outputs stop driving one edge later. An asynchronous active-low output enable gates the data pins. A sleep input freezes all activity and keeps the stored contents.

The data pins are modelled as a value plus a drive flag: `data_oe_o` low stands for high impedance, and `data_o` is then zero.

Top module: `sram_pipe_top`

## Requirements
- R1: While `rst_ni` is low and after it is released, `data_oe_o` is 0 and `data_o` is 0 until a read is presented.
- R2: A read whose address is sampled at rising edge k shows the stored word on `data_o` after edge k+1, with `data_oe_o` = 1 while `out_en_ni` = 0 and `sleep_i` = 0.
- R3: With `all_wr_ni` = 0, a write stores all 32 bits, whatever `lane_wr_ni` and `lane_sel_ni` hold.
- R4: With `all_wr_ni` = 1 and `lane_wr_ni` = 0, a write stores only lane i (bits 8i+7..8i) for each i where `lane_sel_ni[i]` = 0. With every mask bit at 1, nothing changes.
- R5: An access opened by `rd_strobe_ni` = 0 is always a read, and the write inputs are ignored. `rd_strobe_ni` wins when both strobes are low. An access opened by `acc_strobe_ni` alone honours the write inputs.
- R6: The chip is selected only when `en_a_ni` = 0, `en_b_i` = 1 and `en_c_ni` = 0. A start strobe sampled at edge k while unselected closes the access, and `data_oe_o` is 0 after edge k+1 until a new selected start.
- R7: In a cycle with no start strobe and an open access, `advance_ni` = 0 steps the offset n (0 at the start). The address is the base with its two low bits replaced by (base+n) mod 4 when `linear_i` = 1, or by base XOR n when `linear_i` = 0. The upper bits stay fixed and the order wraps after four words.
- R8: In such a cycle with `advance_ni` = 1, the access repeats at the current address.
- R9: Continuation cycles honour the write inputs, so a burst can write.
- R10: `out_en_ni` = 1 forces `data_oe_o` to 0 and `data_o` to 0 at once, with no clock edge needed. Returning it to 0 restores the drive at once.
- R11: While `sleep_i` = 1 all strobes and writes are ignored, `data_oe_o` is 0, the contents are kept, and any open access is closed.
- R12: After edge k+1 following a write sampled at edge k, `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Low-power hold, active high |
| en_a_ni | input | 1 | Chip select, active low |
| en_b_i | input | 1 | Chip select, active high |
| en_c_ni | input | 1 | Chip select, active low |
| rd_strobe_ni | input | 1 | Start strobe that forces a read, active low |
| acc_strobe_ni | input | 1 | Start strobe that honours write inputs, active low |
| advance_ni | input | 1 | Burst offset step, active low |
| linear_i | input | 1 | 1 linear order, 0 interleaved order |
| addr_i | input | ADDR_W | Word address |
| all_wr_ni | input | 1 | Full-word write, active low |
| lane_wr_ni | input | 1 | Masked lane write, active low |
| lane_sel_ni | input | LANES | Per-lane write mask, active low |
| wdata_i | input | DATA_W | Write data |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| data_o | output | DATA_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Drive flag, 0 means high impedance |

## Verification
The bench goes after the burst wrap in both orders from a non-zero base offset. A design that carried into the upper address bits, or that used addition in interleaved mode, would read the wrong word. It issues writes through the read-forcing strobe and through both strobes at once: a design without that priority would corrupt a word that is read back later. It opens and closes accesses with each chip-select input wrong in turn and checks that the drive drops exactly one edge later, not at once and not two edges later. It writes and reads during sleep: a design that only gated the outputs would change memory or leave a burst open after waking. Masked writes with no lane selected, and full-word writes with a mask present, catch a design that got the override order wrong.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_burst.sv
module sram_burst #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [BURST_W-1:0] cnt_i,
  input  logic               linear_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [BURST_W-1:0] lo;

  // linear wraps inside the block, interleaved flips offset bits
  assign lo     = linear_i ? (base_i[BURST_W-1:0] + cnt_i) : (base_i[BURST_W-1:0] ^ cnt_i);
  assign addr_o = {base_i[ADDR_W-1:BURST_W], lo};
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              en_a_ni,
  input  logic              en_b_i,
  input  logic              en_c_ni,
  input  logic              rd_strobe_ni,
  input  logic              acc_strobe_ni,
  input  logic              advance_ni,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              all_wr_ni,
  input  logic              lane_wr_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic [LANES-1:0]  s1_lanes_o,
  output logic [DATA_W-1:0] s1_data_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              active_o
);
  logic               selected;
  logic               any_strobe;
  logic               wr_req;
  logic [LANES-1:0]   wr_lanes;
  logic               active_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic [ADDR_W-1:0]  burst_addr;
  op_e                op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LANES-1:0]   lanes_q;
  logic [DATA_W-1:0]  data_q;

  assign selected   = !en_a_ni && en_b_i && !en_c_ni;
  assign any_strobe = !rd_strobe_ni || !acc_strobe_ni;
  assign wr_req     = !all_wr_ni || !lane_wr_ni;

  // full-word write overrides the lane mask
  always_comb begin
    if (!all_wr_ni)       wr_lanes = '1;
    else if (!lane_wr_ni) wr_lanes = ~lane_sel_ni;
    else                  wr_lanes = '0;
  end

  assign cnt_nxt = advance_ni ? cnt_q : cnt_q + 1'b1;

  sram_burst #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_burst (
    .base_i  (base_q),
    .cnt_i   (cnt_nxt),
    .linear_i(linear_i),
    .addr_o  (burst_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      lanes_q  <= '0;
      data_q   <= '0;
    end else if (sleep_i) begin
      active_q <= 1'b0;
      op_q     <= OP_NONE;
    end else if (any_strobe) begin
      if (selected) begin
        active_q <= 1'b1;
        base_q   <= addr_i;
        cnt_q    <= '0;
        addr_q   <= addr_i;
        data_q   <= wdata_i;
        if (!rd_strobe_ni || !wr_req) begin
          op_q    <= OP_READ;
          lanes_q <= '0;
        end else begin
          op_q    <= OP_WRITE;
          lanes_q <= wr_lanes;
        end
      end else begin
        active_q <= 1'b0;
        op_q     <= OP_NONE;
      end
    end else if (active_q) begin
      cnt_q  <= cnt_nxt;
      addr_q <= burst_addr;
      data_q <= wdata_i;
      if (wr_req) begin
        op_q    <= OP_WRITE;
        lanes_q <= wr_lanes;
      end else begin
        op_q    <= OP_READ;
        lanes_q <= '0;
      end
    end else begin
      op_q <= OP_NONE;
    end
  end

  assign s1_op_o    = op_q;
  assign s1_addr_o  = addr_q;
  assign s1_lanes_o = lanes_q;
  assign s1_data_o  = data_q;
  assign base_o     = base_q;
  assign active_o   = active_q;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  lanes_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lanes_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_out.sv
module sram_out
  import sram_pipe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  op_e               s1_op_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] q_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      vld_q <= 1'b0;
    end else if (sleep_i) begin
      vld_q <= 1'b0;
    end else if (s1_op_i == OP_READ) begin
      q_q   <= rdata_i;
      vld_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
    end
  end

  // asynchronous gating of the pins
  assign data_oe_o = vld_q && !out_en_ni && !sleep_i;
  assign data_o    = data_oe_o ? q_q : '0;
  assign vld_o     = vld_q;
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              en_a_ni,
  input  logic              en_b_i,
  input  logic              en_c_ni,
  input  logic              rd_strobe_ni,
  input  logic              acc_strobe_ni,
  input  logic              advance_ni,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              all_wr_ni,
  input  logic              lane_wr_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic [DATA_W-1:0] s1_data;
  logic [ADDR_W-1:0] base;
  logic              active;
  logic [DATA_W-1:0] rdata;
  logic              rd_vld;
  logic              arr_we;

  sram_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_i      (sleep_i),
    .en_a_ni      (en_a_ni),
    .en_b_i       (en_b_i),
    .en_c_ni      (en_c_ni),
    .rd_strobe_ni (rd_strobe_ni),
    .acc_strobe_ni(acc_strobe_ni),
    .advance_ni   (advance_ni),
    .linear_i     (linear_i),
    .addr_i       (addr_i),
    .all_wr_ni    (all_wr_ni),
    .lane_wr_ni   (lane_wr_ni),
    .lane_sel_ni  (lane_sel_ni),
    .wdata_i      (wdata_i),
    .s1_op_o      (s1_op),
    .s1_addr_o    (s1_addr),
    .s1_lanes_o   (s1_lanes),
    .s1_data_o    (s1_data),
    .base_o       (base),
    .active_o     (active)
  );

  assign arr_we = (s1_op == OP_WRITE) && !sleep_i;

  sram_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_array (
    .clk_i  (clk_i),
    .we_i   (arr_we),
    .lanes_i(s1_lanes),
    .addr_i (s1_addr),
    .wdata_i(s1_data),
    .rdata_o(rdata)
  );

  sram_out #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .s1_op_i  (s1_op),
    .rdata_i  (rdata),
    .out_en_ni(out_en_ni),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .vld_o    (rd_vld)
  );
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              en_a_ni,
  input logic              en_b_i,
  input logic              en_c_ni,
  input logic              rd_strobe_ni,
  input logic              acc_strobe_ni,
  input op_e               s1_op_i,
  input logic [ADDR_W-1:0] s1_addr_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              active_i,
  input logic              rd_vld_i
);
  logic strobe;
  logic unsel;

  assign strobe = !rd_strobe_ni || !acc_strobe_ni;
  assign unsel  = en_a_ni || !en_b_i || en_c_ni;

  assert_read_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_op_i == OP_READ && !sleep_i) |=> rd_vld_i);

  assert_rd_strobe_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_strobe_ni && !sleep_i) |=> (s1_op_i != OP_WRITE));

  assert_deselect_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && unsel && !sleep_i) |=> ##1 !rd_vld_i);

  assert_burst_in_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !strobe && !sleep_i)
      |=> (s1_addr_i[ADDR_W-1:BURST_W] == base_i[ADDR_W-1:BURST_W]));

  assert_sleep_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!rd_vld_i && !active_i && s1_op_i == OP_NONE));

  assert_write_no_drive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_op_i == OP_WRITE) |=> !rd_vld_i);
endmodule

bind sram_pipe_top sram_pipe_chk #(
  .ADDR_W (ADDR_W),
  .BURST_W(BURST_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_i      (sleep_i),
  .en_a_ni      (en_a_ni),
  .en_b_i       (en_b_i),
  .en_c_ni      (en_c_ni),
  .rd_strobe_ni (rd_strobe_ni),
  .acc_strobe_ni(acc_strobe_ni),
  .s1_op_i      (s1_op),
  .s1_addr_i    (s1_addr),
  .base_i       (base),
  .active_i     (active),
  .rd_vld_i     (rd_vld)
);

// File: tb/sim_sram_pipe_top.sv
module sim_sram_pipe_top;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep = 1'b0;
  logic          ena = 1'b0, enb = 1'b1, enc = 1'b0;
  logic          rd_n = 1'b1, acc_n = 1'b1, adv_n = 1'b1, lin = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1, bw_n = 1'b1;
  logic [3:0]    bsel_n = 4'hf;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  sram_pipe_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep),
    .en_a_ni(ena), .en_b_i(enb), .en_c_ni(enc),
    .rd_strobe_ni(rd_n), .acc_strobe_ni(acc_n), .advance_ni(adv_n), .linear_i(lin),
    .addr_i(addr), .all_wr_ni(gw_n), .lane_wr_ni(bw_n), .lane_sel_ni(bsel_n),
    .wdata_i(wdata), .out_en_ni(oe_n), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int            tgt;
    logic          oe;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  exp_t          cur;
  logic [DW-1:0] mdl [1 << AW];
  bit            act = 0;
  logic [AW-1:0] base = '0;
  logic [1:0]    cnt = '0;

  task automatic check(string tag, logic [DW-1:0] actual, logic [DW-1:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, logic [1:0] n, bit linear);
    logic [1:0] lo;
    lo = linear ? b[1:0] + n : b[1:0] ^ n;
    return {b[AW-1:2], lo};
  endfunction

  // monitor: pop expectations due in this cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].tgt <= cyc) begin
      cur = sbq.pop_front();
      check({cur.tag, " drive"}, {31'b0, data_oe_o}, {31'b0, cur.oe});
      check({cur.tag, " data"}, data_o, cur.data);
    end
  end

  // driver: apply one cycle of inputs, predict the result two edges later
  task automatic step(string tag, bit rs, bit as, bit adv, bit gw, bit bw,
                      logic [3:0] bs, logic [AW-1:0] a, logic [DW-1:0] wd, bit probe = 0);
    exp_t          e;
    logic [AW-1:0] ad;
    bit            do_acc, is_wr;
    logic [3:0]    lanes;
    rd_n = rs; acc_n = as; adv_n = adv; gw_n = gw; bw_n = bw;
    bsel_n = bs; addr = a; wdata = wd;
    e.tgt = cyc + 2; e.tag = tag; e.oe = 1'b0; e.data = '0;
    do_acc = 0; is_wr = 0; ad = '0;
    if (sleep) begin
      act = 0;
    end else if (!rs || !as) begin
      if (!ena && enb && !enc) begin
        act = 1; base = a; cnt = 2'd0; ad = a; do_acc = 1;
        is_wr = rs && (!gw || !bw);
      end else begin
        act = 0;
      end
    end else if (act) begin
      if (!adv) cnt = cnt + 2'd1;
      ad = burst_addr(base, cnt, lin); do_acc = 1;
      is_wr = !gw || !bw;
    end
    if (do_acc) begin
      if (is_wr) begin
        lanes = !gw ? 4'hf : ~bs;
        for (int i = 0; i < 4; i++)
          if (lanes[i]) mdl[ad][i*8 +: 8] = wd[i*8 +: 8];
      end else begin
        e.oe = 1'b1; e.data = mdl[ad];
      end
    end
    sbq.push_back(e);
    if (probe) begin
      #12;
      oe_n = 1'b1;
      #1;
      check("R10 drive off", {31'b0, data_oe_o}, 32'd0);
      check("R10 data off", data_o, 32'd0);
      oe_n = 1'b0;
      #1;
      check("R10 drive back", {31'b0, data_oe_o}, 32'd1);
    end
    @(posedge clk); #2;
  endtask

  task automatic idle(string tag);
    step(tag, 1, 1, 1, 1, 1, 4'hf, '0, '0);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 drive in reset", {31'b0, data_oe_o}, 32'd0);
    check("R1 data in reset", data_o, 32'd0);
    @(posedge clk); #2;
    rst_ni = 1'b1;
    @(posedge clk); #2;
    idle("R1 idle after reset");
    idle("R1 idle after reset");

    // full-word writes with a mask present, burst continuation writes
    step("R3", 1, 0, 1, 0, 0, 4'b1110, 6'd0, 32'h1111_1111);
    step("R9", 1, 1, 0, 0, 1, 4'hf, 6'd0, 32'h2222_2222);
    step("R9", 1, 1, 0, 0, 1, 4'hf, 6'd0, 32'h3333_3333);
    step("R9", 1, 1, 0, 0, 1, 4'hf, 6'd0, 32'h4444_4444);
    step("R12", 1, 1, 1, 1, 1, 4'hf, 6'd0, '0);

    // linear burst from offset 1, wraps to 0, then suspend
    step("R2", 1, 0, 1, 1, 1, 4'hf, 6'd1, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    step("R8", 1, 1, 1, 1, 1, 4'hf, 6'd0, '0);

    // interleaved from offset 3
    lin = 1'b0;
    step("R2", 0, 1, 1, 1, 1, 4'hf, 6'd3, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    step("R7", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    lin = 1'b1;

    // masked lane writes
    step("R4", 1, 0, 1, 1, 0, 4'b1010, 6'd2, 32'hAABB_CCDD);
    step("R4", 0, 1, 1, 1, 1, 4'hf, 6'd2, '0);
    step("R4", 1, 0, 1, 1, 0, 4'hf, 6'd2, 32'hFFFF_FFFF);
    step("R4", 0, 1, 1, 1, 1, 4'hf, 6'd2, '0);

    // read-forcing strobe ignores write inputs and has priority
    step("R5", 0, 1, 1, 0, 1, 4'hf, 6'd3, 32'hDEAD_BEEF);
    step("R5", 0, 0, 1, 0, 0, 4'h0, 6'd1, 32'hBEEF_DEAD);
    step("R5", 0, 1, 1, 1, 1, 4'hf, 6'd3, '0);
    step("R5", 0, 1, 1, 1, 1, 4'hf, 6'd1, '0);

    // write following a read stops the drive
    step("R12", 1, 0, 1, 0, 1, 4'hf, 6'd5, 32'h5555_AAAA);
    step("R12", 1, 0, 1, 1, 1, 4'hf, 6'd5, '0);

    // each select input wrong in turn
    for (int k = 0; k < 3; k++) begin
      step("R6 open", 0, 1, 1, 1, 1, 4'hf, 6'd0, '0);
      if (k == 0) ena = 1'b1;
      if (k == 1) enb = 1'b0;
      if (k == 2) enc = 1'b1;
      step("R6 deselect", 1, 0, 1, 1, 1, 4'hf, 6'd0, '0);
      ena = 1'b0; enb = 1'b1; enc = 1'b0;
      idle("R6 stays off");
    end

    // asynchronous output enable
    step("R10 read", 0, 1, 1, 1, 1, 4'hf, 6'd2, '0);
    step("R10 hold", 1, 1, 1, 1, 1, 4'hf, 6'd0, '0);
    step("R10 hold", 1, 1, 1, 1, 1, 4'hf, 6'd0, '0, 1);
    step("R10 hold", 1, 1, 1, 1, 1, 4'hf, 6'd0, '0);

    // sleep: quiet the pipe first, then try to write and read
    ena = 1'b1;
    step("R11 close", 1, 0, 1, 1, 1, 4'hf, 6'd0, '0);
    ena = 1'b0;
    idle("R11 quiet");
    sleep = 1'b1;
    step("R11 write asleep", 1, 0, 1, 0, 1, 4'hf, 6'd0, 32'h0BAD_0BAD);
    step("R11 read asleep", 0, 1, 1, 1, 1, 4'hf, 6'd0, '0);
    step("R11 advance asleep", 1, 1, 0, 0, 1, 4'hf, 6'd0, 32'h0BAD_0BAD);
    sleep = 1'b0;
    idle("R11 closed after wake");
    idle("R11 closed after wake");
    step("R11 retained", 0, 1, 1, 1, 1, 4'hf, 6'd0, '0);
    step("R11 retained", 1, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    ena = 1'b1;
    step("R6 final close", 1, 0, 1, 1, 1, 4'hf, 6'd0, '0);
    ena = 1'b0;
    idle("R6 final idle");
    idle("R6 final idle");

    repeat (3) @(posedge clk);
    #2;
    check("scoreboard drained", sbq.size(), 0);
    finish_run();
  end
endmodule